// File: doc/BRIEF.md
# Split-Transaction Priority Request Queue

This block is the target side of a split-transaction port. A master pushes read and write requests, each tagged and marked high or low priority, without waiting for earlier data. Requests go into a low-priority store and a high-priority store. The high-priority store keeps reads and writes in two separate lanes. Requests are then issued to a memory read-command port, or turned into write-data pulls towards the master.

Read data from memory passes through a return queue and goes back to the master when the target chooses. Each returned item carries its priority and tag. Write data is pulled from the master only while a slot in the write-data buffer is reserved for it. A credit counter mirrors the master's view of how many requests are outstanding, and it gates acceptance of new requests.

Top module: `rq_split_queue`

## Requirements
- R1: An accepted read is later issued on the read-command port with its tag. The memory response is paired with that tag and appears on the return port.
- R2: Several requests can be accepted back to back with none of them completed, up to CREDITS outstanding.
- R3: While either high-priority lane holds a request, no low-priority request is issued, neither as a read command nor as a pull.
- R4: Low-priority requests issue in strict arrival order across reads and writes. A low write queued behind a read that is stalled on the read-command port is not pulled.
- R5: High-priority reads keep their order among themselves, and so do high-priority writes. A stalled high read does not hold back a high write.
- R6: The return port raises ret_valid_o for one cycle per item, without any ready input. ret_prio_o is 1 for high and 0 for low. Items from one sub-queue come back in request order.
- R7: pull_valid_o is raised only while fewer than WBUF pulls await a drain on the write-memory port. Write data leaves on that port in pull order, each item with its tag.
- R8: credit_o resets to CREDITS. It decreases by one for each accepted request and increases by one for each ret_valid_o cycle and for each wdat_valid_i cycle. At zero, both req_ready_o bits are 0.
- R9: req_ready_o bit 1 is high priority and bit 0 is low priority. A full low store clears only bit 0. A full high read lane or a full high write lane clears only bit 1.
- R10: An enqueue and a dequeue on the same store in one cycle keep its occupancy consistent, so a continuous stream loses and duplicates nothing.
- R11: After reset, no valid output is raised, credit_o equals CREDITS and both ready bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_prio_i | input | 1 | 1 = high priority |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_tag_i | input | TW | Request tag |
| req_ready_o | output | 2 | Accept per priority (bit 1 high, bit 0 low) |
| credit_o | output | clog2(CREDITS+1) | Remaining request credits |
| rd_cmd_valid_o | output | 1 | Read command to memory |
| rd_cmd_ready_i | input | 1 | Memory accepts read command |
| rd_cmd_tag_o | output | TW | Read command tag |
| rd_cmd_prio_o | output | 1 | Read command priority |
| rd_rsp_valid_i | input | 1 | Memory read data valid (in command order) |
| rd_rsp_data_i | input | DW | Memory read data |
| ret_valid_o | output | 1 | Read data returned to master |
| ret_prio_o | output | 1 | Priority of returned read |
| ret_tag_o | output | TW | Tag of returned read |
| ret_data_o | output | DW | Returned read data |
| pull_valid_o | output | 1 | Ask master for write data |
| pull_tag_o | output | TW | Tag of pulled write |
| wdat_valid_i | input | 1 | Master supplies write data (in pull order) |
| wdat_i | input | DW | Write data |
| wmem_valid_o | output | 1 | Write to memory |
| wmem_ready_i | input | 1 | Memory accepts write |
| wmem_tag_o | output | TW | Write tag |
| wmem_data_o | output | DW | Write data |

## Verification
The assertions take three things for granted about the environment. Memory answers reads only for commands it has accepted, and in command order. The master supplies write data only for pulls it has already seen, and in pull order. The master never offers a request on a priority whose ready bit is low. The bench keeps to all three: its memory model queues each accepted command and answers one per cycle from that queue, its master model answers each observed pull once, and its request task waits on the matching ready bit before it holds a request over a clock edge. Stalls are produced only by holding rd_cmd_ready_i or wmem_ready_i low, and never by breaking an ordering.

// File: rtl/rq_pkg.sv
package rq_pkg;
  // which store feeds an issue lane this cycle
  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_HI   = 2'd1,
    LANE_LO   = 2'd2
  } lane_e;
endpackage

// File: rtl/rq_fifo.sv
module rq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_i,
  input  logic [W-1:0]                  data_i,
  input  logic                          pop_i,
  output logic [W-1:0]                  data_o,
  output logic                          empty_o,
  output logic                          full_o,
  output logic [$clog2(DEPTH+1)-1:0]    count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wptr_q <= bump(wptr_q);
      if (pop_i)  rptr_q <= bump(rptr_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign data_o  = mem_q[rptr_q];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rq_credit.sv
module rq_credit #(
  parameter int CREDITS = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          take_i,
  input  logic                          give_rd_i,
  input  logic                          give_wr_i,
  output logic [$clog2(CREDITS+1)-1:0]  credit_o,
  output logic                          has_o
);
  localparam int CRW = $clog2(CREDITS+1);
  logic [CRW-1:0] credit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= CRW'(CREDITS);
    else         credit_q <= credit_q - CRW'(take_i) + CRW'(give_rd_i) + CRW'(give_wr_i);
  end

  assign credit_o = credit_q;
  assign has_o    = (credit_q != '0);

  p_credit_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= CRW'(CREDITS));
  p_no_take_at_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> credit_q != '0);
endmodule

// File: rtl/rq_issue_arb.sv
module rq_issue_arb
  import rq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hr_ne_i,
  input  logic  hw_ne_i,
  input  logic  lo_ne_i,
  input  logic  lo_wr_i,
  input  logic  wspace_i,
  input  logic  rd_ready_i,
  output lane_e rd_lane_o,
  output lane_e wr_lane_o,
  output logic  pop_hr_o,
  output logic  pop_hw_o,
  output logic  pop_lo_o
);
  // high lanes run independently; low store waits until both are empty
  always_comb begin
    rd_lane_o = LANE_IDLE;
    wr_lane_o = LANE_IDLE;
    if (hr_ne_i || hw_ne_i) begin
      if (hr_ne_i)             rd_lane_o = LANE_HI;
      if (hw_ne_i && wspace_i) wr_lane_o = LANE_HI;
    end else if (lo_ne_i) begin
      if (!lo_wr_i)      rd_lane_o = LANE_LO;
      else if (wspace_i) wr_lane_o = LANE_LO;
    end
  end

  assign pop_hr_o = (rd_lane_o == LANE_HI) && rd_ready_i;
  assign pop_hw_o = (wr_lane_o == LANE_HI);
  assign pop_lo_o = ((rd_lane_o == LANE_LO) && rd_ready_i) || (wr_lane_o == LANE_LO);

  p_lo_after_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_lo_o |-> !hr_ne_i && !hw_ne_i);
  p_pull_needs_space_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lane_o != LANE_IDLE) |-> wspace_i);
endmodule

// File: rtl/rq_split_queue.sv
module rq_split_queue
  import rq_pkg::*;
#(
  parameter int TW      = 8,
  parameter int DW      = 16,
  parameter int QDEPTH  = 4,
  parameter int CREDITS = 8,
  parameter int WBUF    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic                          req_prio_i,
  input  logic                          req_write_i,
  input  logic [TW-1:0]                 req_tag_i,
  output logic [1:0]                    req_ready_o,
  output logic [$clog2(CREDITS+1)-1:0]  credit_o,
  output logic                          rd_cmd_valid_o,
  input  logic                          rd_cmd_ready_i,
  output logic [TW-1:0]                 rd_cmd_tag_o,
  output logic                          rd_cmd_prio_o,
  input  logic                          rd_rsp_valid_i,
  input  logic [DW-1:0]                 rd_rsp_data_i,
  output logic                          ret_valid_o,
  output logic                          ret_prio_o,
  output logic [TW-1:0]                 ret_tag_o,
  output logic [DW-1:0]                 ret_data_o,
  output logic                          pull_valid_o,
  output logic [TW-1:0]                 pull_tag_o,
  input  logic                          wdat_valid_i,
  input  logic [DW-1:0]                 wdat_i,
  output logic                          wmem_valid_o,
  input  logic                          wmem_ready_i,
  output logic [TW-1:0]                 wmem_tag_o,
  output logic [DW-1:0]                 wmem_data_o
);
  localparam int QCW = $clog2(QDEPTH+1);
  localparam int PCW = $clog2(CREDITS+1);
  localparam int BCW = $clog2(WBUF+1);
  localparam int RW  = 1 + TW + DW;

  logic has_credit, accept;
  logic hr_push, hw_push, lo_push, pop_hr, pop_hw, pop_lo;
  logic hr_empty, hw_empty, lo_empty, hr_full, hw_full, lo_full;
  logic [TW-1:0] hr_head, hw_head;
  logic [TW:0]   lo_head;
  logic [QCW-1:0] hr_cnt, hw_cnt, lo_cnt;
  lane_e rd_lane, wr_lane;
  logic rd_fire, wmem_fire;

  // request intake
  assign req_ready_o[1] = has_credit && !hr_full && !hw_full;
  assign req_ready_o[0] = has_credit && !lo_full;
  assign accept  = req_valid_i && req_ready_o[req_prio_i];
  assign hr_push = accept &&  req_prio_i && !req_write_i;
  assign hw_push = accept &&  req_prio_i &&  req_write_i;
  assign lo_push = accept && !req_prio_i;

  rq_fifo #(.W(TW), .DEPTH(QDEPTH)) u_hr (
    .clk_i, .rst_ni, .push_i(hr_push), .data_i(req_tag_i), .pop_i(pop_hr),
    .data_o(hr_head), .empty_o(hr_empty), .full_o(hr_full), .count_o(hr_cnt));
  rq_fifo #(.W(TW), .DEPTH(QDEPTH)) u_hw (
    .clk_i, .rst_ni, .push_i(hw_push), .data_i(req_tag_i), .pop_i(pop_hw),
    .data_o(hw_head), .empty_o(hw_empty), .full_o(hw_full), .count_o(hw_cnt));
  rq_fifo #(.W(TW+1), .DEPTH(QDEPTH)) u_lo (
    .clk_i, .rst_ni, .push_i(lo_push), .data_i({req_write_i, req_tag_i}), .pop_i(pop_lo),
    .data_o(lo_head), .empty_o(lo_empty), .full_o(lo_full), .count_o(lo_cnt));

  // write-data reservation: one tag slot per outstanding pull
  logic wtag_empty, wtag_full, wdat_empty, wdat_full;
  logic [BCW-1:0] wtag_cnt, wdat_cnt;

  rq_issue_arb u_arb (
    .clk_i, .rst_ni,
    .hr_ne_i(!hr_empty), .hw_ne_i(!hw_empty), .lo_ne_i(!lo_empty),
    .lo_wr_i(lo_head[TW]), .wspace_i(!wtag_full), .rd_ready_i(rd_cmd_ready_i),
    .rd_lane_o(rd_lane), .wr_lane_o(wr_lane),
    .pop_hr_o(pop_hr), .pop_hw_o(pop_hw), .pop_lo_o(pop_lo));

  assign rd_cmd_valid_o = (rd_lane != LANE_IDLE);
  assign rd_cmd_prio_o  = (rd_lane == LANE_HI);
  assign rd_cmd_tag_o   = (rd_lane == LANE_HI) ? hr_head : lo_head[TW-1:0];
  assign rd_fire        = rd_cmd_valid_o && rd_cmd_ready_i;

  assign pull_valid_o = (wr_lane != LANE_IDLE);
  assign pull_tag_o   = (wr_lane == LANE_HI) ? hw_head : lo_head[TW-1:0];

  assign wmem_valid_o = !wdat_empty;
  assign wmem_fire    = wmem_valid_o && wmem_ready_i;

  rq_fifo #(.W(TW), .DEPTH(WBUF)) u_wtag (
    .clk_i, .rst_ni, .push_i(pull_valid_o), .data_i(pull_tag_o), .pop_i(wmem_fire),
    .data_o(wmem_tag_o), .empty_o(wtag_empty), .full_o(wtag_full), .count_o(wtag_cnt));
  rq_fifo #(.W(DW), .DEPTH(WBUF)) u_wdat (
    .clk_i, .rst_ni, .push_i(wdat_valid_i), .data_i(wdat_i), .pop_i(wmem_fire),
    .data_o(wmem_data_o), .empty_o(wdat_empty), .full_o(wdat_full), .count_o(wdat_cnt));

  // read path: tags wait for in-order memory data, then drain one per cycle
  logic [TW:0]    pend_head;
  logic           pend_empty, pend_full, ret_empty, ret_full;
  logic [PCW-1:0] pend_cnt, ret_cnt;
  logic [RW-1:0]  ret_head;

  rq_fifo #(.W(TW+1), .DEPTH(CREDITS)) u_pend (
    .clk_i, .rst_ni, .push_i(rd_fire), .data_i({rd_cmd_prio_o, rd_cmd_tag_o}),
    .pop_i(rd_rsp_valid_i), .data_o(pend_head), .empty_o(pend_empty),
    .full_o(pend_full), .count_o(pend_cnt));
  rq_fifo #(.W(RW), .DEPTH(CREDITS)) u_ret (
    .clk_i, .rst_ni, .push_i(rd_rsp_valid_i), .data_i({pend_head, rd_rsp_data_i}),
    .pop_i(!ret_empty), .data_o(ret_head), .empty_o(ret_empty),
    .full_o(ret_full), .count_o(ret_cnt));

  assign ret_valid_o = !ret_empty;
  assign {ret_prio_o, ret_tag_o, ret_data_o} = ret_head;

  rq_credit #(.CREDITS(CREDITS)) u_credit (
    .clk_i, .rst_ni, .take_i(accept), .give_rd_i(ret_valid_o), .give_wr_i(wdat_valid_i),
    .credit_o(credit_o), .has_o(has_credit));

  p_rsp_expected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rsp_valid_i |-> !pend_empty);
  p_wdat_owed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdat_valid_i |-> wtag_cnt > wdat_cnt);
  p_req_honours_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_prio_i && hr_full |-> !accept);
  p_ret_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o && ret_cnt == PCW'(1) && !rd_rsp_valid_i |=> !ret_valid_o);
endmodule

// File: tb/tb_rq_split_queue.sv
module tb_rq_split_queue;
  localparam int TW = 8, DW = 16, QDEPTH = 4, CREDITS = 8, WBUF = 2;
  localparam int CRW = $clog2(CREDITS+1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_prio_i = 0, req_write_i = 0;
  logic [TW-1:0] req_tag_i = '0;
  logic [1:0] req_ready_o;
  logic [CRW-1:0] credit_o;
  logic rd_cmd_valid_o, rd_cmd_ready_i = 0, rd_cmd_prio_o;
  logic [TW-1:0] rd_cmd_tag_o;
  logic rd_rsp_valid_i = 0;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic ret_valid_o, ret_prio_o;
  logic [TW-1:0] ret_tag_o;
  logic [DW-1:0] ret_data_o;
  logic pull_valid_o;
  logic [TW-1:0] pull_tag_o;
  logic wdat_valid_i = 0;
  logic [DW-1:0] wdat_i = '0;
  logic wmem_valid_o, wmem_ready_i = 0;
  logic [TW-1:0] wmem_tag_o;
  logic [DW-1:0] wmem_data_o;

  rq_split_queue #(.TW(TW), .DW(DW), .QDEPTH(QDEPTH), .CREDITS(CREDITS), .WBUF(WBUF)) dut (.*);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int issue_log [128]; int issue_n = 0;
  int ret_log   [128]; int ret_n   = 0;
  int wmem_log  [128]; int wmem_n  = 0;
  logic [TW-1:0] rsp_q [128]; int rsp_w = 0; int rsp_r = 0;
  logic [TW-1:0] pq    [128]; int pq_w  = 0; int pq_r  = 0;

  function automatic logic [DW-1:0] rdata(input logic [TW-1:0] t); return {t, ~t}; endfunction
  function automatic logic [DW-1:0] wdata(input logic [TW-1:0] t); return {~t, t}; endfunction
  function automatic int enc(input int wr, input int pr, input int t); return wr*512 + pr*256 + t; endfunction

  // observe transfers at the edge (values before update)
  always @(posedge clk_i) if (rst_ni) begin
    if (rd_cmd_valid_o && rd_cmd_ready_i) begin
      issue_log[issue_n % 128] <= enc(0, int'(rd_cmd_prio_o), int'(rd_cmd_tag_o));
      issue_n <= issue_n + 1;
      rsp_q[rsp_w % 128] <= rd_cmd_tag_o; rsp_w <= rsp_w + 1;
    end else if (pull_valid_o) begin
      issue_log[issue_n % 128] <= enc(1, 0, int'(pull_tag_o));
      issue_n <= issue_n + 1;
    end
    if (pull_valid_o) begin pq[pq_w % 128] <= pull_tag_o; pq_w <= pq_w + 1; end
    if (ret_valid_o) begin
      ret_log[ret_n % 128] <= (ret_data_o == rdata(ret_tag_o)) ? enc(0, int'(ret_prio_o), int'(ret_tag_o)) : -1;
      ret_n <= ret_n + 1;
    end
    if (wmem_valid_o && wmem_ready_i) begin
      wmem_log[wmem_n % 128] <= (wmem_data_o == wdata(wmem_tag_o)) ? int'(wmem_tag_o) : -1;
      wmem_n <= wmem_n + 1;
    end
  end

  // memory and master data models: answer in order, one per cycle
  always @(negedge clk_i) begin
    if (rsp_r < rsp_w) begin
      rd_rsp_valid_i <= 1'b1; rd_rsp_data_i <= rdata(rsp_q[rsp_r % 128]); rsp_r <= rsp_r + 1;
    end else rd_rsp_valid_i <= 1'b0;
    if (pq_r < pq_w) begin
      wdat_valid_i <= 1'b1; wdat_i <= wdata(pq[pq_r % 128]); pq_r <= pq_r + 1;
    end else wdat_valid_i <= 1'b0;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic pr, input logic wr, input logic [TW-1:0] t);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_prio_i = pr; req_write_i = wr; req_tag_i = t;
    while (!req_ready_o[pr]) @(negedge clk_i);
  endtask

  task automatic idle();
    @(negedge clk_i); req_valid_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // {prio, write, tag}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h01}, {1'b1, 1'b0, 8'h02}, {1'b0, 1'b1, 8'h03},
    {1'b1, 1'b1, 8'h04}, {1'b0, 1'b0, 8'hFE}, {1'b1, 1'b1, 8'h80}};

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b, rb, wb;
    wait_n(3);
    // R11: reset state
    chk(credit_o == CRW'(CREDITS), "R11 credit", int'(credit_o), CREDITS);
    chk(req_ready_o == 2'b11, "R11 ready", int'(req_ready_o), 3);
    chk(!rd_cmd_valid_o && !ret_valid_o && !pull_valid_o && !wmem_valid_o, "R11 valids", 1, 0);
    rst_ni = 1'b1;
    rd_cmd_ready_i = 1'b1; wmem_ready_i = 1'b1;

    // table walk: R1 reads round trip, R7 writes round trip, R8 credit restored
    foreach (VEC[i]) begin
      rb = ret_n; wb = wmem_n;
      send(VEC[i][9], VEC[i][8], VEC[i][7:0]);
      idle();
      wait_n(12);
      if (!VEC[i][8])
        chk(ret_n == rb + 1 && ret_log[rb % 128] == enc(0, int'(VEC[i][9]), int'(VEC[i][7:0])),
            "R1 R6 read return", ret_log[rb % 128], enc(0, int'(VEC[i][9]), int'(VEC[i][7:0])));
      else
        chk(wmem_n == wb + 1 && wmem_log[wb % 128] == int'(VEC[i][7:0]),
            "R7 write drain", wmem_log[wb % 128], int'(VEC[i][7:0]));
      chk(credit_o == CRW'(CREDITS), "R8 credit back", int'(credit_o), CREDITS);
    end

    // R3: high before low; R6 prio on return
    rd_cmd_ready_i = 1'b0; b = issue_n; rb = ret_n;
    send(0, 0, 8'h10); send(0, 0, 8'h11); send(1, 0, 8'h20); send(1, 0, 8'h21); idle();
    chk(credit_o == CRW'(CREDITS-4), "R2 outstanding", int'(credit_o), CREDITS-4);
    rd_cmd_ready_i = 1'b1; wait_n(20);
    chk(issue_log[b % 128] == enc(0,1,'h20) && issue_log[(b+1) % 128] == enc(0,1,'h21), "R3 hi first",
        issue_log[b % 128], enc(0,1,'h20));
    chk(issue_log[(b+2) % 128] == enc(0,0,'h10) && issue_log[(b+3) % 128] == enc(0,0,'h11), "R3 lo after",
        issue_log[(b+2) % 128], enc(0,0,'h10));
    chk(ret_log[rb % 128] == enc(0,1,'h20) && ret_log[(rb+3) % 128] == enc(0,0,'h11), "R6 return order",
        ret_log[(rb+3) % 128], enc(0,0,'h11));

    // R4: low write behind stalled low read is not pulled
    rd_cmd_ready_i = 1'b0; b = issue_n; wb = wmem_n;
    send(0, 0, 8'h30); send(0, 1, 8'h31); idle(); wait_n(6);
    chk(issue_n == b && !pull_valid_o, "R4 write held", issue_n - b, 0);
    rd_cmd_ready_i = 1'b1; wait_n(20);
    chk(issue_log[b % 128] == enc(0,0,'h30) && issue_log[(b+1) % 128] == enc(1,0,'h31), "R4 arrival order",
        issue_log[(b+1) % 128], enc(1,0,'h31));
    chk(wmem_log[wb % 128] == 'h31, "R4 write data", wmem_log[wb % 128], 'h31);

    // R5: stalled high read does not block high write; low waits (R3)
    rd_cmd_ready_i = 1'b0; b = issue_n;
    send(1, 0, 8'h40); send(1, 1, 8'h41); send(0, 1, 8'h42); idle(); wait_n(8);
    chk(issue_n == b + 1 && issue_log[b % 128] == enc(1,0,'h41), "R5 hi write passes",
        issue_log[b % 128], enc(1,0,'h41));
    rd_cmd_ready_i = 1'b1; wait_n(20);
    chk(issue_log[(b+1) % 128] == enc(0,1,'h40) && issue_log[(b+2) % 128] == enc(1,0,'h42), "R5 R3 then low",
        issue_log[(b+2) % 128], enc(1,0,'h42));
    chk(credit_o == CRW'(CREDITS), "R8 credit after mix", int'(credit_o), CREDITS);

    // R9 / R8: full low store and credit exhaustion
    rd_cmd_ready_i = 1'b0;
    for (int k = 0; k < QDEPTH; k++) send(0, 0, 8'h50 + 8'(k));
    idle(); wait_n(1);
    chk(req_ready_o == 2'b10, "R9 low full only", int'(req_ready_o), 2);
    chk(credit_o == CRW'(CREDITS-QDEPTH), "R8 credit down", int'(credit_o), CREDITS-QDEPTH);
    for (int k = 0; k < QDEPTH; k++) send(1, 0, 8'h58 + 8'(k));
    idle(); wait_n(1);
    chk(credit_o == '0, "R8 credit zero", int'(credit_o), 0);
    chk(req_ready_o == 2'b00, "R8 R9 no ready", int'(req_ready_o), 0);
    rd_cmd_ready_i = 1'b1; wait_n(30);
    chk(credit_o == CRW'(CREDITS), "R8 credit refill", int'(credit_o), CREDITS);

    // R7: write buffer space gates pulls
    wmem_ready_i = 1'b0; b = issue_n; wb = wmem_n;
    send(0, 1, 8'h60); send(0, 1, 8'h61); send(0, 1, 8'h62); idle(); wait_n(10);
    chk(issue_n == b + WBUF, "R7 pulls limited", issue_n - b, WBUF);
    chk(credit_o == CRW'(CREDITS-1), "R8 write credit", int'(credit_o), CREDITS-1);
    wmem_ready_i = 1'b1; wait_n(15);
    chk(wmem_n == wb + 3 && wmem_log[wb % 128] == 'h60 && wmem_log[(wb+2) % 128] == 'h62, "R7 drain order",
        wmem_log[(wb+2) % 128], 'h62);

    // R10: continuous stream with concurrent push and pop
    rb = ret_n;
    for (int k = 0; k < 6; k++) send(0, 0, 8'h70 + 8'(k));
    idle(); wait_n(25);
    chk(ret_n == rb + 6, "R10 stream count", ret_n - rb, 6);
    for (int k = 0; k < 6; k++)
      chk(ret_log[(rb+k) % 128] == enc(0,0,'h70+k), "R10 stream order", ret_log[(rb+k) % 128], enc(0,0,'h70+k));
    chk(credit_o == CRW'(CREDITS), "R10 credit end", int'(credit_o), CREDITS);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule